// File: doc/BRIEF.md
# Register Access Violation Monitor

This block sits beside a small register file and watches every access on its simple register bus: an address, a read strobe and a write strobe. A parameter map gives each register slot its attributes: read-only, write-only, protected, or none of these. An address is defined only when it is aligned to the register stride and falls inside the map. The block spots three kinds of misuse and records them in a read-only status word. The first is a write to a protected register while the protection input is high. The second is a read of a write-only register. The third is a write to a read-only register, or any access to an undefined address.

The monitor also drives a write-enable gate, `wrAllow`, that the register file uses in place of the raw write strobe. A blocked or illegal write therefore never reaches its target. The status word is presented all the time, and it has its own read strobe. That strobe clears the sticky content at the clock edge where the read takes place. An event that arrives in the same cycle as the read survives into the following read.

Top module: `reg_guard`

## Requirements
- R1: After reset the status word is all zeros and stays zero while no access occurs.
- R2: Status word layout: bit 0 is the protection-violation flag, bit 3 the software-error flag, bits 23:8 the captured 16-bit offset, and bits 25:24 the error type. The type codes are 0 for a read of a write-only register, 1 for a write to a read-only register and 2 for an access to an undefined address. Code 3 never appears, and every other bit reads 0.
- R3: A write to a defined protected register while `protEn` is 1 sets bit 0 and holds `wrAllow` at 0 during that cycle. Bit 0 stays set until the status word is read.
- R4: When `protEn` is 0, a write to a protected register is treated as an ordinary write to its slot and raises no protection violation.
- R5: A read of a defined write-only register sets bit 3 with type 0.
- R6: A write to a defined read-only register that is not itself a protection violation sets bit 3 with type 1 and holds `wrAllow` at 0.
- R7: A read or write of an undefined offset sets bit 3 with type 2, and a write there holds `wrAllow` at 0. An offset is undefined when it is not a multiple of 4 or when its index (offset/4) is 8 or more. The default map has 8 slots: 0-1 read-only, 2-3 write-only, 4-7 read/write, and 2, 4 and 5 protected.
- R8: Address ownership works as follows. The first protection violation since the last status read owns bits 23:8, and later events leave them unchanged. With no violation held, the first software error owns them. A violation that follows a held software error replaces the address.
- R9: The type field keeps the code of the first software error since the last status read.
- R10: A status read (`statusRd` = 1) returns the current word. It clears the flags, the address and the type at that clock edge. An event in the same cycle is recorded afresh after the clear.
- R11: `wrAllow` is 1 only for a write to a defined, non-read-only slot that is not blocked by protection. Legal accesses raise no flag.
- R12: When `busRd` and `busWr` are both 1, the access is handled as a write only. The read side is not classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Byte offset of the current access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| protEn | input | 1 | Write protection enable |
| statusRd | input | 1 | Read strobe for the status word (clear on read) |
| wrAllow | output | 1 | Gated write enable for the register file |
| statusWord | output | 32 | Status word |

## Verification
The hardest states to reach are those where events pile up between two status reads. Examples are a software error followed by a protection violation that takes the address over, a later error that must not disturb either field, and an event that lands in the same cycle as the clearing read. The bench reaches these with directed multi-step sequences. Before them, it sweeps every offset from 0 to 39 with read and write under both settings of the protection input, clearing with a status read after each access. A step-by-step model built from the requirements predicts the word and the write gate.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;

  localparam int STATUS_W = 32;
  localparam int OFFS_W   = 16;

  typedef enum logic [1:0] {
    ERR_READ_WO  = 2'd0,
    ERR_WRITE_RO = 2'd1,
    ERR_UNDEF    = 2'd2
  } errKind_t;

  // strobes passed from the classifier (control) to the status datapath
  typedef struct packed {
    logic              viol;
    logic              swErr;
    errKind_t          kind;
    logic [OFFS_W-1:0] offs;
  } evStrobes_t;

  localparam int POS_VIOL  = 0;
  localparam int POS_SWERR = 3;
  localparam int POS_OFFS  = 8;
  localparam int POS_KIND  = 24;

endpackage

// File: rtl/reg_guard_classify.sv
module reg_guard_classify
  import reg_guard_pkg::*;
#(
  parameter int                   NUM_REGS    = 8,
  parameter int                   STRIDE_LOG2 = 2,
  parameter logic [NUM_REGS-1:0]  RO_MASK     = 8'b0000_0011,
  parameter logic [NUM_REGS-1:0]  WO_MASK     = 8'b0000_1100,
  parameter logic [NUM_REGS-1:0]  PROT_MASK   = 8'b0011_0100
) (
  input  logic [OFFS_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              protEn,
  output evStrobes_t        ev,
  output logic              wrAllow
);

  localparam logic [OFFS_W-1:0] LOW_MASK = OFFS_W'((1 << STRIDE_LOG2) - 1);

  logic [OFFS_W-1:0]   slotIdx;
  logic                aligned;
  logic [NUM_REGS-1:0] slotHit;
  logic                isDef, isRo, isWo, isProt;
  logic                readOnly;

  assign slotIdx  = busAddr >> STRIDE_LOG2;
  assign aligned  = (busAddr & LOW_MASK) == '0;
  // a read that coincides with a write is not classified
  assign readOnly = busRd & ~busWr;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_slot
      assign slotHit[gi] = aligned && (slotIdx == OFFS_W'(gi));
    end
  endgenerate

  assign isDef  = |slotHit;
  assign isRo   = |(slotHit & RO_MASK);
  assign isWo   = |(slotHit & WO_MASK);
  assign isProt = |(slotHit & PROT_MASK);

  always_comb begin
    ev       = '0;
    ev.offs  = busAddr;
    ev.kind  = ERR_UNDEF;
    wrAllow  = 1'b0;
    if (busWr) begin
      if (!isDef) begin
        ev.swErr = 1'b1;
        ev.kind  = ERR_UNDEF;
      end else if (isProt && protEn) begin
        ev.viol  = 1'b1;
      end else if (isRo) begin
        ev.swErr = 1'b1;
        ev.kind  = ERR_WRITE_RO;
      end else begin
        wrAllow  = 1'b1;
      end
    end else if (readOnly) begin
      if (!isDef) begin
        ev.swErr = 1'b1;
        ev.kind  = ERR_UNDEF;
      end else if (isWo) begin
        ev.swErr = 1'b1;
        ev.kind  = ERR_READ_WO;
      end
    end
  end

endmodule

// File: rtl/reg_guard_status.sv
module reg_guard_status
  import reg_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  evStrobes_t          ev,
  input  logic                statusRd,
  output logic [STATUS_W-1:0] statusWord
);

  logic              violQ, swErrQ;
  errKind_t          kindQ;
  logic [OFFS_W-1:0] offsQ;

  logic              violD, swErrD;
  errKind_t          kindD;
  logic [OFFS_W-1:0] offsD;
  logic              holdViol, holdSw;

  // a status read drops what is held; this cycle's event still lands
  assign holdViol = violQ  & ~statusRd;
  assign holdSw   = swErrQ & ~statusRd;

  always_comb begin
    violD  = holdViol | ev.viol;
    swErrD = holdSw   | ev.swErr;

    if (ev.viol && !holdViol)
      offsD = ev.offs;
    else if (ev.swErr && !holdViol && !holdSw)
      offsD = ev.offs;
    else if (holdViol || holdSw)
      offsD = offsQ;
    else
      offsD = '0;

    if (ev.swErr && !holdSw)
      kindD = ev.kind;
    else if (holdSw)
      kindD = kindQ;
    else
      kindD = ERR_READ_WO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violQ  <= 1'b0;
      swErrQ <= 1'b0;
      kindQ  <= ERR_READ_WO;
      offsQ  <= '0;
    end else begin
      violQ  <= violD;
      swErrQ <= swErrD;
      kindQ  <= kindD;
      offsQ  <= offsD;
    end
  end

  always_comb begin
    statusWord                            = '0;
    statusWord[POS_VIOL]                  = violQ;
    statusWord[POS_SWERR]                 = swErrQ;
    statusWord[POS_OFFS +: OFFS_W]        = offsQ;
    statusWord[POS_KIND +: 2]             = kindQ;
  end

endmodule

// File: rtl/reg_guard.sv
module reg_guard
  import reg_guard_pkg::*;
#(
  parameter int                   NUM_REGS    = 8,
  parameter int                   STRIDE_LOG2 = 2,
  parameter logic [NUM_REGS-1:0]  RO_MASK     = 8'b0000_0011,
  parameter logic [NUM_REGS-1:0]  WO_MASK     = 8'b0000_1100,
  parameter logic [NUM_REGS-1:0]  PROT_MASK   = 8'b0011_0100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] busAddr,
  input  logic        busRd,
  input  logic        busWr,
  input  logic        protEn,
  input  logic        statusRd,
  output logic        wrAllow,
  output logic [31:0] statusWord
);

  evStrobes_t evBus;

  reg_guard_classify #(
    .NUM_REGS(NUM_REGS), .STRIDE_LOG2(STRIDE_LOG2),
    .RO_MASK(RO_MASK), .WO_MASK(WO_MASK), .PROT_MASK(PROT_MASK)
  ) u_classify (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .protEn(protEn),
    .ev(evBus), .wrAllow(wrAllow)
  );

  reg_guard_status u_status (
    .clk(clk), .rstN(rstN), .ev(evBus), .statusRd(statusRd),
    .statusWord(statusWord)
  );

endmodule

// File: rtl/reg_guard_chk.sv
module reg_guard_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busRd,
  input logic        busWr,
  input logic        protEn,
  input logic        statusRd,
  input logic        wrAllow,
  input logic [31:0] statusWord
);

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> statusWord == 32'd0);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:26] == 6'd0 && statusWord[7:4] == 4'd0 && statusWord[2:1] == 2'd0);

  assert_type_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[25:24] != 2'd3);

  assert_viol_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] && !statusRd |=> statusWord[0]);

  assert_no_viol_unprot_R4: assert property (@(posedge clk) disable iff (!rstN)
    !protEn && !statusWord[0] |=> !statusWord[0]);

  assert_addr_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] && !statusRd |=> $stable(statusWord[23:8]));

  assert_type_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[3] && !statusRd |=> statusWord[3] && $stable(statusWord[25:24]));

  assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && !busRd && !busWr |=> statusWord == 32'd0);

  assert_write_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrAllow |-> busWr);

endmodule

bind reg_guard reg_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .protEn(protEn),
  .statusRd(statusRd), .wrAllow(wrAllow), .statusWord(statusWord)
);

// File: tb/reg_guard_tb.sv
module reg_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RO_M   = 8'b0000_0011;
  localparam logic [7:0] WO_M   = 8'b0000_1100;
  localparam logic [7:0] PROT_M = 8'b0011_0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0, protEn = 1'b0, statusRd = 1'b0;
  logic        wrAllow;
  logic [31:0] statusWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model of the status content
  bit          mViol = 0, mSw = 0;
  logic [1:0]  mKind = 0;
  logic [15:0] mOffs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_guard u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .protEn(protEn), .statusRd(statusRd), .wrAllow(wrAllow), .statusWord(statusWord)
  );

  function automatic logic [31:0] packWord();
    return {6'd0, mKind, mOffs, 4'd0, mSw, 2'd0, mViol};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive, check gate and status, advance model
  task automatic step(input string req, input logic [15:0] a, input bit rd, input bit wr,
                      input bit pe, input bit srd);
    int  idx;
    bit  def, viol, sw, expAllow;
    logic [1:0] kind;
    bit  hv, hs;
    @(negedge clk);
    busAddr = a; busRd = rd; busWr = wr; protEn = pe; statusRd = srd;
    idx  = int'(a >> 2);
    def  = (a[1:0] == 2'b00) && (idx < 8);
    viol = 0; sw = 0; kind = 0; expAllow = 0;
    if (wr) begin
      if (!def) begin sw = 1; kind = 2; end
      else if (PROT_M[idx] && pe) viol = 1;
      else if (RO_M[idx]) begin sw = 1; kind = 1; end
      else expAllow = 1;
    end else if (rd) begin
      if (!def) begin sw = 1; kind = 2; end
      else if (WO_M[idx]) begin sw = 1; kind = 0; end
    end
    #1;
    check({req, " wrAllow"}, {31'd0, wrAllow}, {31'd0, expAllow});
    check({req, " status"}, statusWord, packWord());
    hv = mViol && !srd;
    hs = mSw && !srd;
    if (viol && !hv) mOffs = a;
    else if (sw && !hv && !hs) mOffs = a;
    else if (!(hv || hs)) mOffs = 0;
    if (sw && !hs) mKind = kind;
    else if (!hs) mKind = 0;
    mViol = hv || viol;
    mSw   = hs || sw;
  endtask

  task automatic idle(input string req, input bit srd);
    step(req, 16'h0000, 0, 0, 0, srd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset", statusWord, 32'd0);
    rstN = 1'b1;
    idle("R1 idle", 0);
    idle("R1 idle", 0);

    // sweep: every offset, read/write, protection off/on (R2-R7, R11)
    for (int a = 0; a < 40; a++) begin
      for (int m = 0; m < 4; m++) begin
        step("R2-sweep R3 R4 R5 R6 R7 R11", 16'(a), m[0] == 1'b0, m[0] == 1'b1, m[1], 0);
        idle("R10 readback", 1);
      end
    end
    idle("R10 cleared", 0);

    // R8: software error then violation takes address, later error ignored
    step("R5 swe first",      16'h0008, 1, 0, 1, 0);
    step("R8 viol overrides", 16'h0010, 0, 1, 1, 0);
    step("R8 addr locked",    16'h0000, 0, 1, 1, 0);
    step("R9 type kept",      16'h0030, 1, 0, 1, 0);
    step("R8 second viol",    16'h0014, 0, 1, 1, 0);
    idle("R8 read", 1);
    idle("R10 after clear", 0);

    // R9: first software error type retained, address from first error
    step("R6 ro write",       16'h0004, 0, 1, 0, 0);
    step("R9 undef later",    16'h0021, 1, 0, 0, 0);
    step("R9 wo read later",  16'h000C, 1, 0, 0, 0);
    idle("R9 read", 1);

    // R10: event in the same cycle as the status read survives
    step("R6 ro write",       16'h0000, 0, 1, 0, 0);
    step("R10 same-cycle",    16'h0022, 0, 1, 0, 1);
    idle("R10 kept", 1);
    step("R3 viol",           16'h0008, 0, 1, 1, 0);
    step("R10 viol same-cycle", 16'h0010, 0, 1, 1, 1);
    idle("R10 viol kept", 1);
    idle("R10 empty", 0);

    // R12: simultaneous read and write treated as write only
    step("R12 rw on wo",      16'h000C, 1, 1, 0, 0);
    step("R12 rw on ro",      16'h0000, 1, 1, 0, 0);
    idle("R12 read", 1);
    step("R12 rw on rw",      16'h0018, 1, 1, 1, 0);
    step("R4 prot off write", 16'h0014, 0, 1, 0, 0);
    step("R11 legal read",    16'h001C, 1, 0, 1, 0);
    idle("R11 no flags", 1);
    idle("R1 final", 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule